// File: doc/BRIEF.md
# Capture Pin Conditioner with Majority-Free Sample Filter

This block sits between one external pin and the capture stage of a timer. The pin is first brought into the clock domain by a synchronizer. An optional digital noise filter then judges the pin level from a run of samples. A capture enable gates the chosen signal, and the result is the internal capture level. The block also gives a one-clock strobe on each rising and each falling transition of that level. A capture register downstream uses these strobes.

The enable gate and the filter select act on the internal level directly, so changing either one can create an edge that the pin did not make. This is deliberate. Software that wants no false strobe must clear the enable before it changes the filter select. Filter samples are taken only on cycles where the sampling strobe is high.

Top module: `icf_frontend`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `cap_lvl_o`, `rise_o` and `fall_o` are 0. Reset clears the sample history to all zeros and sets the filtered level to 0.
- R2: While `cap_en_i` is 0, `cap_lvl_o` is 0 one clock later, whatever the pin and the filter select do.
- R3: With the filter deselected (`filt_sel_i`=0) and capture enabled, a pin value applied before clock edge k appears on `cap_lvl_o` after edge k+2. That is two synchronizer flops and one output register.
- R4: The filter pushes the synchronized pin into a five-entry history only on edges where `samp_en_i` is 1. On other edges the history does not change.
- R5: The filtered level becomes 1 one edge after all five history entries are 1. It becomes 0 one edge after all five are 0. Otherwise it keeps its value.
- R6: `rise_o` is 1 for exactly the cycle in which `cap_lvl_o` has just changed from 0 to 1. `fall_o` is 1 for exactly the cycle in which it has just changed from 1 to 0.
- R7: Setting `cap_en_i` while the selected source is high gives a rising edge. Clearing it gives a falling edge.
- R8: With capture enabled, changing `filt_sel_i` while the filtered level and the synchronized pin differ gives an edge toward the newly selected source.
- R9: A pin pulse that spans fewer than five samples does not move `cap_lvl_o` while the filter is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Raw external pin |
| cap_en_i | input | 1 | Use the pin as a capture input |
| filt_sel_i | input | 1 | 1 selects the filtered level, 0 the synchronized pin |
| samp_en_i | input | 1 | Sampling strobe for the filter |
| cap_lvl_o | output | 1 | Internal capture level |
| rise_o | output | 1 | One-clock rising edge strobe |
| fall_o | output | 1 | One-clock falling edge strobe |

## Verification
Some properties are checked on every cycle by assertions. A low enable forces the level low. The history stays frozen when there is no sampling strobe. The filtered level changes only after a history that fully agrees. The unfiltered path follows the synchronizer, and each strobe lasts one cycle.

Other behaviour can only be shown by the bench's scenarios, which compare every output against a behavioural model. These cover the false edges made by toggling the enable or the filter select, glitches shorter than the filter window being rejected, and the exact latency from pin to strobe.

// File: rtl/icf_pkg.sv
package icf_pkg;
    localparam int unsigned ICF_SYNC_STAGES = 2;
    localparam int unsigned ICF_FILT_TAPS   = 5;

    typedef struct packed {
        logic cur;
        logic prev;
    } icf_edge_st_t;
endpackage

// File: rtl/icf_sync.sv
module icf_sync #(
    parameter int unsigned STAGES = icf_pkg::ICF_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    localparam int unsigned MSB = STAGES - 1;

    logic [MSB:0] sh_d, sh_q;

    generate
        if (STAGES > 1) begin : g_multi
            always_comb sh_d = {sh_q[MSB-1:0], d_i};
        end else begin : g_single
            always_comb sh_d = d_i;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q_o = sh_q[MSB];
endmodule

// File: rtl/icf_filter.sv
module icf_filter #(
    parameter int unsigned TAPS = icf_pkg::ICF_FILT_TAPS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic samp_en_i,
    input  logic d_i,
    output logic lvl_o
);
    localparam int unsigned MSB = TAPS - 1;

    typedef struct packed {
        logic [MSB:0] hist;
        logic         lvl;
    } filt_st_t;

    filt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (samp_en_i) st_d.hist = {st_q.hist[MSB-1:0], d_i};
        if (&st_q.hist)       st_d.lvl = 1'b1;
        else if (~|st_q.hist) st_d.lvl = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl_o = st_q.lvl;

    AST_HIST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !samp_en_i |=> $stable(st_q.hist)); // R4
    AST_LVL_NEEDS_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.lvl != $past(st_q.lvl)) |->
        ($past(st_q.hist) == '1 || $past(st_q.hist) == '0)); // R5
endmodule

// File: rtl/icf_edge.sv
module icf_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic lvl_o,
    output logic rise_o,
    output logic fall_o
);
    icf_pkg::icf_edge_st_t st_d, st_q;

    always_comb begin
        st_d.prev = st_q.cur;
        st_d.cur  = lvl_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl_o  = st_q.cur;
    assign rise_o = st_q.cur & ~st_q.prev;
    assign fall_o = ~st_q.cur & st_q.prev;

    AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o); // R6
    AST_FALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o); // R6
endmodule

// File: rtl/icf_frontend.sv
module icf_frontend #(
    parameter int unsigned SYNC_STAGES = icf_pkg::ICF_SYNC_STAGES,
    parameter int unsigned FILT_TAPS   = icf_pkg::ICF_FILT_TAPS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic cap_en_i,
    input  logic filt_sel_i,
    input  logic samp_en_i,
    output logic cap_lvl_o,
    output logic rise_o,
    output logic fall_o
);
    logic sync_q;
    logic filt_lvl;
    logic cap_d;

    icf_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(sync_q)
    );

    icf_filter #(.TAPS(FILT_TAPS)) u_filt (
        .clk(clk), .rst_n(rst_n), .samp_en_i(samp_en_i),
        .d_i(sync_q), .lvl_o(filt_lvl)
    );

    always_comb cap_d = cap_en_i & (filt_sel_i ? filt_lvl : sync_q);

    icf_edge u_edge (
        .clk(clk), .rst_n(rst_n), .lvl_i(cap_d),
        .lvl_o(cap_lvl_o), .rise_o(rise_o), .fall_o(fall_o)
    );

    AST_EN_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en_i |=> !cap_lvl_o); // R2
    AST_RAW_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en_i && !filt_sel_i) |=> (cap_lvl_o == $past(sync_q))); // R3
endmodule

// File: tb/icf_frontend_tb.sv
module icf_frontend_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pin = 1'b0, en = 1'b0, fsel = 1'b0, samp = 1'b0;
    logic lvl, rise, fall;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    string tag = "R1";

    // behavioural reference state
    bit m_s1, m_s2, m_flt, m_cap, m_prev;
    bit m_hist[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    icf_frontend u_dut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin), .cap_en_i(en),
        .filt_sel_i(fsel), .samp_en_i(samp),
        .cap_lvl_o(lvl), .rise_o(rise), .fall_o(fall)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_flt = 0; m_cap = 0; m_prev = 0;
            m_hist = '{0, 0, 0, 0, 0};
        end else begin
            int ones;
            ones = 0;
            foreach (m_hist[i]) ones += m_hist[i];
            m_prev = m_cap;
            m_cap  = en && (fsel ? m_flt : m_s2);
            if (ones == 5) m_flt = 1;
            else if (ones == 0) m_flt = 0;
            if (samp) begin
                m_hist.push_front(m_s2);
                void'(m_hist.pop_back());
            end
            m_s2 = m_s1;
            m_s1 = pin;
        end
    end

    task automatic check(string what, logic act, bit exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0b expected=%0b (cycle %0d)", tag, what, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        check("cap_lvl", lvl, m_cap);
        check("R6 rise", rise, m_cap && !m_prev);
        check("R6 fall", fall, !m_cap && m_prev);
        if (cycles > WATCHDOG) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected<=%0d", cycles, WATCHDOG);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wait_n(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        tag = "R1";
        wait_n(3);
        rst_n = 1'b1;
        wait_n(2);

        tag = "R2"; // enable low: pin and selects have no effect
        for (int i = 0; i < 12; i++) begin
            pin = i[0]; fsel = i[2]; samp = 1'b1;
            wait_n(1);
        end
        fsel = 0; pin = 0; wait_n(4);

        tag = "R3"; // unfiltered path, several periods
        en = 1;
        for (int p = 1; p <= 4; p++)
            for (int k = 0; k < 4; k++) begin
                pin = ~pin; wait_n(p);
            end
        pin = 1; wait_n(5);

        tag = "R7"; // enable toggling while pin high
        en = 0; wait_n(3);
        en = 1; wait_n(3);
        en = 0; wait_n(1);
        en = 1; wait_n(4);

        tag = "R9"; // short glitches under the filter
        en = 0; pin = 0; wait_n(4);
        fsel = 1; samp = 1; wait_n(8);
        en = 1; wait_n(2);
        pin = 1; wait_n(3); pin = 0; wait_n(10);
        pin = 1; wait_n(4); pin = 0; wait_n(10);

        tag = "R5"; // long stable level settles the filter
        pin = 1; wait_n(12);
        pin = 0; wait_n(4); pin = 1; wait_n(12);
        pin = 0; wait_n(12);

        tag = "R4"; // sampling strobe gating
        samp = 0; pin = 1; wait_n(15);
        for (int i = 0; i < 24; i++) begin
            samp = i[0]; wait_n(1);
        end
        pin = 0;
        for (int i = 0; i < 24; i++) begin
            samp = (i % 3 == 0); wait_n(1);
        end
        samp = 1; wait_n(8);

        tag = "R8"; // filter select switched while sources differ
        samp = 0; pin = 1; wait_n(4);
        fsel = 0; wait_n(3);
        fsel = 1; wait_n(3);
        fsel = 0; wait_n(2);
        samp = 1; wait_n(10);
        pin = 0; samp = 0; wait_n(4);
        fsel = 1; wait_n(3);
        fsel = 0; wait_n(3);

        tag = "R6";
        samp = 1; fsel = 0;
        for (int i = 0; i < 10; i++) begin
            pin = ~pin; wait_n(1 + (i % 3));
        end
        wait_n(4);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule